// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings an SDRAM device from power-up into service and then keeps it refreshed. A single pulse on `start` launches the power-up walk. The walk issues one precharge-all, then a fixed number of auto (CBR) refreshes, then a mode-register write. After that the block enters normal operation. During the walk an internal operation selector picks the command that the next access slot will carry. Each command is issued by an access slot that the sequencer makes itself once the selector is set. The current selector value is visible on `op_mode`.

In normal operation the block turns each requested access into a transfer strobe. It also issues one refresh each time a two-stage counter expires. The first stage is a prescaler and the second stage is the refresh timer. Both stage limits come in as ports. Every command holds the command bus for a fixed number of cycles. A refresh that expires while the bus is held is kept pending and goes out as soon as the bus frees, ahead of any waiting access.

Top module: `sdram_init_seq`

## Requirements
- R1: After `start`, the first command strobe is a precharge-all, the refreshes follow it, and the mode-register write comes last, with no other command in between.
- R2: The power-up walk issues exactly INIT_REFS refresh strobes (default 8) before the mode-register write.
- R3: `op_mode` encodes the selected operation: 0 normal, 1 precharge-all, 2 refresh, 3 mode-register write. Every power-up strobe appears while `op_mode` holds that command's code.
- R4: Command strobes last one cycle and are mutually exclusive. After any strobe, no new strobe appears until the bus has been held for CMD_CYC cycles.
- R5: Before `start`, no command strobe appears and `init_done` stays low. `init_done` rises only after the mode-register write has finished.
- R6: `acc_req` is ignored until `init_done` is high. After that, each free bus slot in which `acc_req` is high yields exactly one `cmd_xfer` strobe.
- R7: In normal operation with no access traffic, refresh strobes are spaced exactly (presc+1)*(rtimer+1) cycles apart.
- R8: Once high, `init_done` stays high until reset, and `op_mode` reads 0 (normal) while it is high.
- R9: A refresh that expires while the bus is held is deferred and never dropped. It takes priority over a waiting access, so under continuous access traffic two successive refreshes are never more than period+CMD_CYC+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the power-up walk (honoured only when idle) |
| presc | input | PW | Refresh prescaler limit; the stage counts presc+1 cycles |
| rtimer | input | TW | Refresh timer limit; the stage counts rtimer+1 prescaler wraps |
| acc_req | input | 1 | Access request; level, sampled in each free bus slot |
| cmd_pre | output | 1 | Precharge-all strobe |
| cmd_ref | output | 1 | Auto-refresh strobe |
| cmd_mrw | output | 1 | Mode-register write strobe |
| cmd_xfer | output | 1 | Normal transfer strobe |
| op_mode | output | 2 | Currently selected operation code |
| init_done | output | 1 | Power-up walk finished; normal operation with refresh |
| busy | output | 1 | Command bus held by the last command |

## Verification
The bench builds the block with PW=4, TW=4, CMD_CYC=2 and INIT_REFS=8. The narrow limits make refresh periods of 4, 10 and 12 cycles practical, so many refresh intervals fit in a short run. A period of 4 cycles sits just above the 3-cycle command slot, which puts the limit of refresh deferral within reach. Holding `acc_req` high through a long window keeps the bus almost always taken. This shows that a deferred refresh still goes out within one slot and that no expiry is lost.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int PW        = 8,
  parameter int TW        = 8,
  parameter int CMD_CYC   = 2,
  parameter int INIT_REFS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] presc,
  input  logic [TW-1:0] rtimer,
  input  logic          acc_req,
  output logic          cmd_pre,
  output logic          cmd_ref,
  output logic          cmd_mrw,
  output logic          cmd_xfer,
  output logic [1:0]    op_mode,
  output logic          init_done,
  output logic          busy
);
  localparam int BW = $clog2(CMD_CYC + 1);
  localparam int NW = $clog2(INIT_REFS + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_REF, S_MRW, S_RUN} st_t;

  st_t           st;
  logic          sent;
  logic [BW-1:0] bcnt;
  logic [NW-1:0] nref;
  logic [PW-1:0] pcnt;
  logic [TW-1:0] tcnt;
  logic          ref_pend;

  wire bus_free  = (bcnt == '0);
  wire special   = (st == S_PRE) || (st == S_REF) || (st == S_MRW);
  wire fire_init = special && bus_free && !sent;
  wire advance   = special && bus_free && sent;
  wire running   = (st == S_RUN);
  wire expire    = running && (pcnt == presc) && (tcnt == rtimer);
  wire fire_ref  = running && bus_free && ref_pend;
  wire fire_xfer = running && bus_free && !ref_pend && acc_req;

  assign op_mode   = (st == S_PRE) ? 2'd1 :
                     (st == S_REF) ? 2'd2 :
                     (st == S_MRW) ? 2'd3 : 2'd0;
  assign init_done = running;
  assign busy      = !bus_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sent     <= 1'b0;
      bcnt     <= '0;
      nref     <= '0;
      pcnt     <= '0;
      tcnt     <= '0;
      ref_pend <= 1'b0;
      cmd_pre  <= 1'b0;
      cmd_ref  <= 1'b0;
      cmd_mrw  <= 1'b0;
      cmd_xfer <= 1'b0;
    end else begin
      cmd_pre  <= fire_init && (st == S_PRE);
      cmd_ref  <= (fire_init && (st == S_REF)) || fire_ref;
      cmd_mrw  <= fire_init && (st == S_MRW);
      cmd_xfer <= fire_xfer;

      if (fire_init || fire_ref || fire_xfer) bcnt <= BW'(CMD_CYC);
      else if (!bus_free)                     bcnt <= bcnt - 1'b1;

      if (fire_init) sent <= 1'b1;
      else if (advance) sent <= 1'b0;

      case (st)
        S_IDLE: if (start) st <= S_PRE;
        S_PRE:  if (advance) begin st <= S_REF; nref <= '0; end
        S_REF:  if (advance) begin
                  nref <= nref + 1'b1;
                  if (nref == NW'(INIT_REFS - 1)) st <= S_MRW;
                end
        S_MRW:  if (advance) st <= S_RUN;
        default: ;
      endcase

      if (running) begin
        if (pcnt == presc) begin
          pcnt <= '0;
          tcnt <= (tcnt == rtimer) ? '0 : tcnt + 1'b1;
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end

      ref_pend <= expire || (ref_pend && !fire_ref);
    end
  end
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_pre,
  input logic       cmd_ref,
  input logic       cmd_mrw,
  input logic       cmd_xfer,
  input logic [1:0] op_mode,
  input logic       init_done
);
  wire any_cmd = cmd_pre | cmd_ref | cmd_mrw | cmd_xfer;

  assert_onehot_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_pre, cmd_ref, cmd_mrw, cmd_xfer}));

  assert_cmd_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_cmd |=> !any_cmd);

  assert_xfer_after_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_xfer |-> init_done);

  assert_pre_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre |-> (op_mode == 2'd1));

  assert_mrw_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_mrw |-> (op_mode == 2'd3));

  assert_init_ref_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ref && !init_done) |-> (op_mode == 2'd2));

  assert_pre_before_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre |-> !init_done);

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_done_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (op_mode == 2'd0));
endmodule

bind sdram_init_seq sdram_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_pre(cmd_pre), .cmd_ref(cmd_ref),
  .cmd_mrw(cmd_mrw), .cmd_xfer(cmd_xfer), .op_mode(op_mode), .init_done(init_done)
);

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;
  localparam int CLK_P = 10;
  localparam int PW = 4, TW = 4, CC = 2, NR = 8;

  logic clk = 0, rst_n = 0, start = 0, acc_req = 0;
  logic [PW-1:0] presc = '0;
  logic [TW-1:0] rtimer = '0;
  logic cmd_pre, cmd_ref, cmd_mrw, cmd_xfer, init_done, busy;
  logic [1:0] op_mode;

  sdram_init_seq #(.PW(PW), .TW(TW), .CMD_CYC(CC), .INIT_REFS(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .presc(presc), .rtimer(rtimer),
    .acc_req(acc_req), .cmd_pre(cmd_pre), .cmd_ref(cmd_ref), .cmd_mrw(cmd_mrw),
    .cmd_xfer(cmd_xfer), .op_mode(op_mode), .init_done(init_done), .busy(busy));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  int log_code [0:15];
  int log_op   [0:15];
  int nlog = 0, xfer_pre = 0, nref_run = 0, last_ref = 0, nxfer = 0, cyc = 0;
  int min_iv = 0, max_iv = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    nlog = 0; xfer_pre = 0; nref_run = 0; nxfer = 0;
    min_iv = 1000000; max_iv = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!init_done) begin
      if (cmd_pre || cmd_ref || cmd_mrw) begin
        if (nlog < 16) begin
          log_code[nlog] = cmd_pre ? 1 : (cmd_ref ? 2 : 3);
          log_op[nlog]   = int'(op_mode);
        end
        nlog++;
      end
      if (cmd_xfer) xfer_pre++;
    end else begin
      if (cmd_ref) begin
        if (nref_run > 0) begin
          if (cyc - last_ref < min_iv) min_iv = cyc - last_ref;
          if (cyc - last_ref > max_iv) max_iv = cyc - last_ref;
        end
        last_ref = cyc;
        nref_run++;
      end
      if (cmd_xfer) nxfer++;
    end
  end

  task automatic do_reset(input int p, input int t, input bit acc);
    rst_n = 0; start = 0;
    presc = PW'(p); rtimer = TW'(t); acc_req = acc;
    repeat (3) @(posedge clk);
    #1 clear_mon();
  endtask

  task automatic do_init();
    int n;
    rst_n = 1;
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    n = 0;
    while (!init_done && n < 300) begin @(posedge clk); #1 n++; end
    chk(init_done, "R5 init_done after walk", int'(init_done), 1);
  endtask

  task automatic t_reset_idle();
    do_reset(2, 3, 1'b1);
    @(negedge clk);
    chk({cmd_pre, cmd_ref, cmd_mrw, cmd_xfer} == 4'b0, "R5 strobes in reset", {cmd_pre, cmd_ref, cmd_mrw, cmd_xfer}, 0);
    chk(op_mode == 2'd0, "R3 op_mode in reset", op_mode, 0);
    chk(!init_done && !busy, "R5 done/busy in reset", {init_done, busy}, 0);
    @(posedge clk); #1 rst_n = 1;
    repeat (40) @(posedge clk);
    #1;
    chk(nlog == 0, "R5 no command before start", nlog, 0);
    chk(xfer_pre == 0, "R6 no xfer before start", xfer_pre, 0);
    chk(!init_done, "R5 init_done low before start", init_done, 0);
  endtask

  task automatic t_init_order();
    do_reset(2, 3, 1'b1);
    do_init();
    acc_req = 0;
    chk(nlog == NR + 2, "R2 number of walk commands", nlog, NR + 2);
    chk(log_code[0] == 1, "R1 first command precharge", log_code[0], 1);
    for (int i = 1; i <= NR; i++)
      chk(log_code[i] == 2, "R2 refresh in walk", log_code[i], 2);
    chk(log_code[NR + 1] == 3, "R1 last command mode write", log_code[NR + 1], 3);
    for (int i = 0; i < NR + 2; i++)
      chk(log_op[i] == log_code[i], "R3 op_mode matches strobe", log_op[i], log_code[i]);
    chk(xfer_pre == 0, "R6 acc_req ignored during walk", xfer_pre, 0);
    @(negedge clk);
    chk(op_mode == 2'd0, "R8 op_mode normal after walk", op_mode, 0);
  endtask

  task automatic t_refresh_period(input int p, input int t);
    int per;
    per = (p + 1) * (t + 1);
    do_reset(p, t, 1'b0);
    do_init();
    @(posedge clk); #1 clear_mon();
    repeat (per * 8) @(posedge clk);
    #1;
    chk(nref_run >= 7, "R7 refresh count", nref_run, 7);
    chk(min_iv == per, "R7 min refresh interval", min_iv, per);
    chk(max_iv == per, "R7 max refresh interval", max_iv, per);
    chk(init_done, "R8 init_done sticky", init_done, 1);
  endtask

  task automatic t_access();
    do_reset(2, 3, 1'b0);
    do_init();
    @(negedge clk);
    while (!cmd_ref) @(negedge clk);
    @(posedge clk); #1 nxfer = 0; acc_req = 1;
    repeat (2) @(posedge clk);
    #1 acc_req = 0;
    repeat (5) @(posedge clk);
    #1;
    chk(nxfer == 1, "R6 one xfer for one free slot", nxfer, 1);
    acc_req = 1;
    repeat (3) @(posedge clk);
    #1 acc_req = 0;
    repeat (5) @(posedge clk);
    #1;
    chk(nxfer == 2, "R4 one strobe per held slot", nxfer, 2);
  endtask

  task automatic t_defer(input int p, input int t);
    int per;
    per = (p + 1) * (t + 1);
    do_reset(p, t, 1'b0);
    do_init();
    @(posedge clk); #1 clear_mon(); acc_req = 1;
    repeat (per * 12) @(posedge clk);
    #1 acc_req = 0;
    repeat (per + 4) @(posedge clk);
    #1;
    chk(nxfer > 0, "R6 xfers under load", nxfer, 1);
    chk(nref_run >= 11, "R9 refreshes not lost", nref_run, 11);
    chk(max_iv <= per + CC + 1, "R9 deferral bound", max_iv, per + CC + 1);
    chk(min_iv >= per - CC - 1, "R9 deferral lower bound", min_iv, per - CC - 1);
  endtask

  initial begin
    t_reset_idle();
    t_init_order();
    t_refresh_period(2, 3);
    t_refresh_period(0, 9);
    t_refresh_period(3, 0);
    t_access();
    t_defer(2, 3);
    t_defer(3, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule